// File: doc/BRIEF.md
# Buffer Descriptor Ring Manager

This block owns the descriptor rings of a simple Ethernet MAC. All descriptors live in one internal descriptor store, and the host reads and writes that store over a 32-bit register bus. Each descriptor is two words. The first is a status word carrying length, ownership, option and result bits. The second is a buffer address. A programmable transmit count splits the store into two rings. Descriptors below the count form the transmit ring, and the descriptors from the count upward form the receive ring.

On the transmit side the block follows its ring pointer. When software marks the current descriptor ready, the block hands the descriptor's length, buffer address and padding/CRC options to an external transmit datapath with a one-cycle start pulse. When the datapath signals completion, the block writes the result bits back, clears the ready bit and moves on.

On the receive side the block offers the current descriptor's buffer address to the receive datapath. At the end of each frame it fills in the length and error flags and returns the descriptor to software. If the descriptor is still owned by software, the frame is dropped and a busy event is raised. Frame and error events are raised only for descriptors that request an interrupt.

Top module: `bd_ring_mgr`

## Requirements
- R1: Descriptor i has its status word at byte address 0x400+8*i and its buffer address word at 0x404+8*i. Both read back what the host last wrote. Reads of unmapped addresses return 0.
- R2: The transmit count sits at address 0x20 and resets to 64. A write above 128 stores 128. Every write restarts both rings: the transmit pointer goes to index 0 and the receive pointer goes to the index equal to the new count.
- R3: The transmit side starts a descriptor only when its status bit 15 (ready) is set. It then gives one tx_start pulse, with tx_len = bits 31:16, tx_buf_addr = the address word, tx_pad = bit 12 and tx_crc = bit 11. There is never more than one frame in flight.
- R4: On tx_done the status word of the descriptor in flight is rewritten. Bit 15 is cleared, bits 8:0 take tx_result (bit 8 underrun, bits 7:4 retry count, bit 3 retry limit, bit 2 late collision, bit 1 deferred, bit 0 carrier lost), and bits 31:9 other than bit 15 are kept. The new word is readable from the cycle after tx_done.
- R5: After a transmit descriptor completes, the pointer goes to index 0 if its status bit 13 (wrap) is set, or if it was the last index below the transmit count. Otherwise the pointer goes to the next index.
- R6: When bit 14 (interrupt request) of a completing transmit descriptor is set, the block raises one of two one-cycle events. It raises ev_tx_err if tx_result has any of bits 8, 3, 2 or 0 set, and ev_tx_frame otherwise. With bit 14 clear, neither event is raised.
- R7: When rx_frame arrives and the current receive descriptor has bit 15 (empty) set, its status word becomes {rx_len, 0, bits 14:9 kept, rx_flags}. rx_flags bits are: 8 control frame, 7 missed, 6 overrun, 5 invalid symbol, 4 dribble nibble, 3 too long, 2 short, 1 CRC error, 0 late collision. rx_len already counts the 4-byte frame check sequence and is stored as given.
- R8: After a receive descriptor is used, the receive pointer returns to the first receive index (the transmit count) if wrap bit 13 is set or the last store index was used. Otherwise it goes to the next index.
- R9: When rx_frame arrives and the current receive descriptor is not empty, the frame is dropped and ev_rx_busy pulses for one cycle. The descriptor and the receive pointer are left unchanged.
- R10: For a receive descriptor with bit 14 set, the block raises one of two one-cycle events. It raises ev_rx_err if any of rx_flags bits 7:0 is set, and ev_rx_frame otherwise; the control-frame bit 8 alone does not count as an error. With bit 14 clear, neither event is raised.
- R11: rx_buf_addr always shows the address word of the current receive descriptor. rx_ready is high exactly when that descriptor is empty and the receive ring is not zero-sized.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 12 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational) |
| tx_start | output | 1 | One-cycle start of a transmit frame |
| tx_len | output | 16 | Length of the frame being sent |
| tx_buf_addr | output | 32 | Buffer address of the frame being sent |
| tx_pad | output | 1 | Pad short frame option |
| tx_crc | output | 1 | Append CRC option |
| tx_done | input | 1 | Transmit datapath finished the frame |
| tx_result | input | 9 | Transmit result bits, laid out as status bits 8:0 |
| rx_frame | input | 1 | End of a received frame |
| rx_len | input | 16 | Received length including frame check sequence |
| rx_flags | input | 9 | Receive result bits, laid out as status bits 8:0 |
| rx_ready | output | 1 | Current receive descriptor is empty |
| rx_buf_addr | output | 32 | Buffer address of the current receive descriptor |
| ev_tx_frame | output | 1 | Transmit done event |
| ev_tx_err | output | 1 | Transmit error event |
| ev_rx_frame | output | 1 | Receive done event |
| ev_rx_err | output | 1 | Receive error event |
| ev_rx_busy | output | 1 | Frame dropped for lack of an empty descriptor |

## Verification
The transmit side is tried in three ways. First with a descriptor written without its ready bit and then with it, which separates waiting from starting. Then with a second descriptor carrying the wrap bit while a later descriptor is also marked ready, which shows that wrap returns to index 0 and does not run on. Last with results that have and lack error bits, and descriptors with and without the interrupt request bit, which separates the two events from silence. The receive side is fed an error-free frame, a CRC-error frame, a control-only frame and a frame arriving at a descriptor software still owns. These separate write-back, error classification, wrap back to the ring base and the drop path. A final rewrite of the transmit count moves the receive ring's base and shows the restart at the ports.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
    // status word bit positions shared by both rings
    localparam int unsigned OWN_BIT  = 15;  // ready (tx) / empty (rx)
    localparam int unsigned IRQ_BIT  = 14;
    localparam int unsigned WRAP_BIT = 13;
    localparam int unsigned PAD_BIT  = 12;
    localparam int unsigned CRC_BIT  = 11;

    // result bits that count as errors
    localparam logic [8:0] TX_ERR_MASK = 9'h10D;
    localparam logic [8:0] RX_ERR_MASK = 9'h0FF;

    typedef enum logic {TX_IDLE, TX_BUSY} tx_state_e;
endpackage

// File: rtl/bdr_desc_ram.sv
module bdr_desc_ram #(
    parameter int NDESC = 128,
    parameter int IDXW  = $clog2(NDESC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            h_we,
    input  logic            h_sel_addr,
    input  logic [IDXW-1:0] h_idx,
    input  logic [31:0]     h_wdata,
    output logic [31:0]     h_stat,
    output logic [31:0]     h_addr,
    input  logic            tx_we,
    input  logic [IDXW-1:0] tx_idx,
    input  logic [31:0]     tx_wdata,
    output logic [31:0]     tx_stat,
    output logic [31:0]     tx_addr,
    input  logic            rx_we,
    input  logic [IDXW-1:0] rx_idx,
    input  logic [31:0]     rx_wdata,
    output logic [31:0]     rx_stat,
    output logic [31:0]     rx_addr
);
    logic [31:0] stat_q [NDESC];
    logic [31:0] stat_d [NDESC];
    logic [31:0] addr_q [NDESC];
    logic [31:0] addr_d [NDESC];

    // engine write-backs take priority over a host write to the same word
    always_comb begin
        stat_d = stat_q;
        addr_d = addr_q;
        if (h_we) begin
            if (h_sel_addr) addr_d[h_idx] = h_wdata;
            else            stat_d[h_idx] = h_wdata;
        end
        if (tx_we) stat_d[tx_idx] = tx_wdata;
        if (rx_we) stat_d[rx_idx] = rx_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NDESC; i++) begin
                stat_q[i] <= '0;
                addr_q[i] <= '0;
            end
        end else begin
            stat_q <= stat_d;
            addr_q <= addr_d;
        end
    end

    assign h_stat  = stat_q[h_idx];
    assign h_addr  = addr_q[h_idx];
    assign tx_stat = stat_q[tx_idx];
    assign tx_addr = addr_q[tx_idx];
    assign rx_stat = stat_q[rx_idx];
    assign rx_addr = addr_q[rx_idx];

    // the two rings never write the same descriptor
    assert_rings_disjoint_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_we && rx_we) |-> (tx_idx != rx_idx));
endmodule

// File: rtl/bdr_tx_engine.sv
module bdr_tx_engine
    import bdr_pkg::*;
#(
    parameter int NDESC = 128,
    parameter int IDXW  = $clog2(NDESC),
    parameter int CNTW  = $clog2(NDESC + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CNTW-1:0] ring_cnt,
    input  logic            restart,
    input  logic [31:0]     cur_stat,
    input  logic [31:0]     cur_addr,
    output logic [IDXW-1:0] ptr,
    output logic            wb_we,
    output logic [31:0]     wb_data,
    input  logic            tx_done,
    input  logic [8:0]      tx_result,
    output logic            tx_start,
    output logic [15:0]     tx_len,
    output logic [31:0]     tx_buf_addr,
    output logic            tx_pad,
    output logic            tx_crc,
    output logic            ev_frame,
    output logic            ev_err
);
    typedef struct packed {
        tx_state_e       st;
        logic [IDXW-1:0] ptr;
        logic            start;
        logic [15:0]     len;
        logic [31:0]     addr;
        logic            pad;
        logic            crc;
        logic            evf;
        logic            eve;
    } tx_regs_t;

    tx_regs_t r_q, r_d;
    logic     ring_on;
    logic     at_end;
    logic     is_err;

    assign ring_on = (ring_cnt != '0);
    assign at_end  = cur_stat[WRAP_BIT] || ((CNTW'(r_q.ptr) + CNTW'(1)) == ring_cnt);
    assign is_err  = |(tx_result & TX_ERR_MASK);

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        r_d.evf   = 1'b0;
        r_d.eve   = 1'b0;
        wb_we     = 1'b0;
        wb_data   = cur_stat;
        if (restart) begin
            r_d.st  = TX_IDLE;
            r_d.ptr = '0;
        end else begin
            case (r_q.st)
                TX_IDLE: begin
                    if (ring_on && cur_stat[OWN_BIT]) begin
                        r_d.st    = TX_BUSY;
                        r_d.start = 1'b1;
                        r_d.len   = cur_stat[31:16];
                        r_d.addr  = cur_addr;
                        r_d.pad   = cur_stat[PAD_BIT];
                        r_d.crc   = cur_stat[CRC_BIT];
                    end
                end
                TX_BUSY: begin
                    if (tx_done) begin
                        wb_we   = 1'b1;
                        wb_data = {cur_stat[31:16], 1'b0, cur_stat[14:9], tx_result};
                        r_d.evf = cur_stat[IRQ_BIT] && !is_err;
                        r_d.eve = cur_stat[IRQ_BIT] && is_err;
                        r_d.ptr = at_end ? '0 : r_q.ptr + IDXW'(1);
                        r_d.st  = TX_IDLE;
                    end
                end
                default: r_d.st = TX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: TX_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign ptr         = r_q.ptr;
    assign tx_start    = r_q.start;
    assign tx_len      = r_q.len;
    assign tx_buf_addr = r_q.addr;
    assign tx_pad      = r_q.pad;
    assign tx_crc      = r_q.crc;
    assign ev_frame    = r_q.evf;
    assign ev_err      = r_q.eve;

    assert_tx_single_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);
    assert_tx_ptr_in_ring_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_on && !restart) |-> (CNTW'(r_q.ptr) < ring_cnt));
    assert_tx_events_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_frame && ev_err));
    // a start is only issued from a descriptor that was ready one cycle earlier
    assert_tx_start_owned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.st == TX_BUSY) |-> $past(cur_stat[OWN_BIT]));
endmodule

// File: rtl/bdr_rx_engine.sv
module bdr_rx_engine
    import bdr_pkg::*;
#(
    parameter int NDESC = 128,
    parameter int IDXW  = $clog2(NDESC),
    parameter int CNTW  = $clog2(NDESC + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CNTW-1:0] ring_base,
    input  logic            restart,
    input  logic [31:0]     cur_stat,
    output logic [IDXW-1:0] ptr,
    output logic            wb_we,
    output logic [31:0]     wb_data,
    input  logic            rx_frame,
    input  logic [15:0]     rx_len,
    input  logic [8:0]      rx_flags,
    output logic            rx_ready,
    output logic            ev_frame,
    output logic            ev_err,
    output logic            ev_busy
);
    typedef struct packed {
        logic [IDXW-1:0] ptr;
        logic            evf;
        logic            eve;
        logic            evb;
    } rx_regs_t;

    rx_regs_t        r_q, r_d;
    logic            ring_on;
    logic            at_end;
    logic            is_err;
    logic [IDXW-1:0] base_idx;

    assign ring_on  = (ring_base < CNTW'(NDESC));
    assign base_idx = IDXW'(ring_base);
    assign at_end   = cur_stat[WRAP_BIT] || ((CNTW'(r_q.ptr) + CNTW'(1)) == CNTW'(NDESC));
    assign is_err   = |(rx_flags & RX_ERR_MASK);
    assign rx_ready = ring_on && cur_stat[OWN_BIT];

    always_comb begin
        r_d     = r_q;
        r_d.evf = 1'b0;
        r_d.eve = 1'b0;
        r_d.evb = 1'b0;
        wb_we   = 1'b0;
        wb_data = cur_stat;
        if (restart) begin
            r_d.ptr = base_idx;
        end else if (rx_frame) begin
            if (rx_ready) begin
                wb_we   = 1'b1;
                wb_data = {rx_len, 1'b0, cur_stat[14:9], rx_flags};
                r_d.evf = cur_stat[IRQ_BIT] && !is_err;
                r_d.eve = cur_stat[IRQ_BIT] && is_err;
                r_d.ptr = at_end ? base_idx : r_q.ptr + IDXW'(1);
            end else begin
                r_d.evb = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ptr      = r_q.ptr;
    assign ev_frame = r_q.evf;
    assign ev_err   = r_q.eve;
    assign ev_busy  = r_q.evb;

    assert_rx_ptr_in_ring_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_on && !restart) |-> (CNTW'(r_q.ptr) >= ring_base));
    assert_rx_events_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_frame, ev_err, ev_busy}));
    // a dropped frame leaves the pointer where it was
    assert_rx_busy_holds_ptr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_frame && !rx_ready && !restart) |=> $stable(r_q.ptr));
endmodule

// File: rtl/bd_ring_mgr.sv
module bd_ring_mgr #(
    parameter int NDESC  = 128,
    parameter int TX_DEF = NDESC / 2,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              tx_start,
    output logic [15:0]       tx_len,
    output logic [31:0]       tx_buf_addr,
    output logic              tx_pad,
    output logic              tx_crc,
    input  logic              tx_done,
    input  logic [8:0]        tx_result,
    input  logic              rx_frame,
    input  logic [15:0]       rx_len,
    input  logic [8:0]        rx_flags,
    output logic              rx_ready,
    output logic [31:0]       rx_buf_addr,
    output logic              ev_tx_frame,
    output logic              ev_tx_err,
    output logic              ev_rx_frame,
    output logic              ev_rx_err,
    output logic              ev_rx_busy
);
    localparam int IDXW = $clog2(NDESC);
    localparam int CNTW = $clog2(NDESC + 1);
    localparam logic [ADDR_W-1:0] DESC_BASE = ADDR_W'('h400);
    localparam logic [ADDR_W-1:0] CNT_OFF   = ADDR_W'('h20);
    localparam logic [ADDR_W-1:0] DESC_SPAN = ADDR_W'(NDESC * 8);

    typedef struct packed {
        logic [CNTW-1:0] cnt;
        logic            restart;
    } top_regs_t;

    top_regs_t r_q, r_d;

    logic [ADDR_W-1:0] off;
    logic              in_desc;
    logic [IDXW-1:0]   h_idx;
    logic              cnt_wr;
    logic [31:0]       h_stat, h_addr_w;
    logic [IDXW-1:0]   tx_ptr, rx_ptr;
    logic              tx_we, rx_we;
    logic [31:0]       tx_wb, rx_wb;
    logic [31:0]       tx_stat, tx_addr_w, rx_stat;

    assign off     = host_addr - DESC_BASE;
    assign in_desc = (host_addr >= DESC_BASE) && (off < DESC_SPAN);
    assign h_idx   = off[IDXW+2:3];
    assign cnt_wr  = host_we && (host_addr == CNT_OFF);

    always_comb begin
        r_d         = r_q;
        r_d.restart = 1'b0;
        if (cnt_wr) begin
            r_d.cnt     = (host_wdata > 32'(NDESC)) ? CNTW'(NDESC) : CNTW'(host_wdata);
            r_d.restart = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{cnt: CNTW'(TX_DEF), restart: 1'b1};
        else        r_q <= r_d;
    end

    always_comb begin
        if (in_desc)                  host_rdata = host_addr[2] ? h_addr_w : h_stat;
        else if (host_addr == CNT_OFF) host_rdata = 32'(r_q.cnt);
        else                          host_rdata = '0;
    end

    bdr_desc_ram #(.NDESC(NDESC), .IDXW(IDXW)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .h_we(host_we && in_desc), .h_sel_addr(host_addr[2]), .h_idx(h_idx),
        .h_wdata(host_wdata), .h_stat(h_stat), .h_addr(h_addr_w),
        .tx_we(tx_we), .tx_idx(tx_ptr), .tx_wdata(tx_wb),
        .tx_stat(tx_stat), .tx_addr(tx_addr_w),
        .rx_we(rx_we), .rx_idx(rx_ptr), .rx_wdata(rx_wb),
        .rx_stat(rx_stat), .rx_addr(rx_buf_addr)
    );

    bdr_tx_engine #(.NDESC(NDESC), .IDXW(IDXW), .CNTW(CNTW)) u_tx (
        .clk(clk), .rst_n(rst_n), .ring_cnt(r_q.cnt), .restart(r_q.restart),
        .cur_stat(tx_stat), .cur_addr(tx_addr_w), .ptr(tx_ptr),
        .wb_we(tx_we), .wb_data(tx_wb), .tx_done(tx_done), .tx_result(tx_result),
        .tx_start(tx_start), .tx_len(tx_len), .tx_buf_addr(tx_buf_addr),
        .tx_pad(tx_pad), .tx_crc(tx_crc), .ev_frame(ev_tx_frame), .ev_err(ev_tx_err)
    );

    bdr_rx_engine #(.NDESC(NDESC), .IDXW(IDXW), .CNTW(CNTW)) u_rx (
        .clk(clk), .rst_n(rst_n), .ring_base(r_q.cnt), .restart(r_q.restart),
        .cur_stat(rx_stat), .ptr(rx_ptr), .wb_we(rx_we), .wb_data(rx_wb),
        .rx_frame(rx_frame), .rx_len(rx_len), .rx_flags(rx_flags),
        .rx_ready(rx_ready), .ev_frame(ev_rx_frame), .ev_err(ev_rx_err),
        .ev_busy(ev_rx_busy)
    );

    assert_cnt_capped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (r_q.cnt <= CNTW'(NDESC)));
endmodule

// File: tb/sim_bd_ring_mgr.sv
module sim_bd_ring_mgr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [11:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        tx_start, tx_pad, tx_crc;
    logic [15:0] tx_len;
    logic [31:0] tx_buf_addr;
    logic        tx_done = 1'b0;
    logic [8:0]  tx_result = '0;
    logic        rx_frame = 1'b0;
    logic [15:0] rx_len = '0;
    logic [8:0]  rx_flags = '0;
    logic        rx_ready;
    logic [31:0] rx_buf_addr;
    logic        ev_tx_frame, ev_tx_err, ev_rx_frame, ev_rx_err, ev_rx_busy;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    bd_ring_mgr u0 (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .tx_start(tx_start), .tx_len(tx_len), .tx_buf_addr(tx_buf_addr),
        .tx_pad(tx_pad), .tx_crc(tx_crc), .tx_done(tx_done), .tx_result(tx_result),
        .rx_frame(rx_frame), .rx_len(rx_len), .rx_flags(rx_flags),
        .rx_ready(rx_ready), .rx_buf_addr(rx_buf_addr),
        .ev_tx_frame(ev_tx_frame), .ev_tx_err(ev_tx_err),
        .ev_rx_frame(ev_rx_frame), .ev_rx_err(ev_rx_err), .ev_rx_busy(ev_rx_busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hr(input logic [11:0] a, output logic [31:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic wait_start(output bit found);
        found = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (tx_start) begin found = 1; break; end
        end
    endtask

    task automatic quiet_tx(input string req);
        bit seen = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (tx_start) seen = 1;
        end
        chk(req, 32'(seen), 32'd0);
    endtask

    task automatic pulse_done(input logic [8:0] res);
        @(negedge clk);
        tx_done = 1'b1; tx_result = res;
        @(negedge clk);
        tx_done = 1'b0;
    endtask

    task automatic pulse_rx(input logic [15:0] len, input logic [8:0] fl);
        @(negedge clk);
        rx_frame = 1'b1; rx_len = len; rx_flags = fl;
        @(negedge clk);
        rx_frame = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        hr(12'h020, d);
        chk("R2 reset count", d, 32'd64);
        chk("R3 no start after reset", 32'(tx_start), 32'd0);
        chk("R6/R10 no events after reset",
            32'({ev_tx_frame, ev_tx_err, ev_rx_frame, ev_rx_err, ev_rx_busy}), 32'd0);
        chk("R11 rx_ready low on cleared store", 32'(rx_ready), 32'd0);
    endtask

    task automatic t_host;
        logic [31:0] d;
        hw(12'h42C, 32'hDEAD_BEEF);
        hr(12'h42C, d);
        chk("R1 address word readback", d, 32'hDEAD_BEEF);
        hw(12'h428, 32'h1234_0055);
        hr(12'h428, d);
        chk("R1 status word readback", d, 32'h1234_0055);
        hr(12'h030, d);
        chk("R1 unmapped reads zero", d, 32'd0);
    endtask

    task automatic t_count;
        logic [31:0] d;
        hw(12'h020, 32'd200);
        hr(12'h020, d);
        chk("R2 count capped at 128", d, 32'd128);
        hw(12'h020, 32'd4);
        hr(12'h020, d);
        chk("R2 count written", d, 32'd4);
    endtask

    task automatic t_tx_basic;
        bit found;
        logic [31:0] d;
        hw(12'h404, 32'h1000_0000);
        hw(12'h400, 32'h0064_5800);
        quiet_tx("R3 no start without ready");
        hw(12'h400, 32'h0064_D800);
        wait_start(found);
        chk("R3 start seen", 32'(found), 32'd1);
        chk("R3 tx_len", 32'(tx_len), 32'd100);
        chk("R3 tx_buf_addr", tx_buf_addr, 32'h1000_0000);
        chk("R3 pad/crc options", 32'({tx_pad, tx_crc}), 32'd3);
        pulse_done(9'h030);
        chk("R6 frame event without error", 32'({ev_tx_frame, ev_tx_err}), 32'b10);
        hr(12'h400, d);
        chk("R4 status written back", d, 32'h0064_5830);
    endtask

    task automatic t_tx_wrap;
        bit found;
        logic [31:0] d;
        hw(12'h40C, 32'h2000_0000);
        hw(12'h414, 32'h3000_0000);
        hw(12'h410, 32'h0010_8000);
        hw(12'h408, 32'h003C_E000);
        wait_start(found);
        chk("R5 next descriptor started", 32'(found), 32'd1);
        chk("R5 index 1 address", tx_buf_addr, 32'h2000_0000);
        pulse_done(9'h104);
        chk("R6 error event", 32'({ev_tx_frame, ev_tx_err}), 32'b01);
        hr(12'h408, d);
        chk("R4 error bits written back", d, 32'h003C_6104);
        quiet_tx("R5 wrap skips ready index 2");
        hw(12'h400, 32'h0050_8000);
        wait_start(found);
        chk("R5 index 0 restarted", 32'(found), 32'd1);
        chk("R5 wrapped to index 0 address", tx_buf_addr, 32'h1000_0000);
        chk("R3 tx_len second frame", 32'(tx_len), 32'd80);
        pulse_done(9'h000);
        chk("R6 no event without irq bit", 32'({ev_tx_frame, ev_tx_err}), 32'b00);
        hr(12'h400, d);
        chk("R4 ready cleared", d, 32'h0050_0000);
    endtask

    task automatic t_rx;
        logic [31:0] d;
        hw(12'h424, 32'h4000_0000);
        hw(12'h42C, 32'h5000_0000);
        hw(12'h420, 32'h0000_C000);
        hw(12'h428, 32'h0000_E000);
        chk("R11 rx_ready on empty", 32'(rx_ready), 32'd1);
        chk("R11 rx_buf_addr at ring base", rx_buf_addr, 32'h4000_0000);
        pulse_rx(16'd68, 9'h000);
        chk("R10 rx frame event", 32'({ev_rx_frame, ev_rx_err, ev_rx_busy}), 32'b100);
        hr(12'h420, d);
        chk("R7 rx status with FCS length", d, 32'h0044_4000);
        chk("R8 pointer advanced", rx_buf_addr, 32'h5000_0000);
        pulse_rx(16'd100, 9'h002);
        chk("R10 rx error event", 32'({ev_rx_frame, ev_rx_err, ev_rx_busy}), 32'b010);
        hr(12'h428, d);
        chk("R7 rx error flags written", d, 32'h0064_6002);
        chk("R8 wrap to ring base", rx_buf_addr, 32'h4000_0000);
        chk("R11 rx_ready low when owned", 32'(rx_ready), 32'd0);
    endtask

    task automatic t_rx_busy;
        logic [31:0] d;
        pulse_rx(16'd50, 9'h000);
        chk("R9 busy event", 32'({ev_rx_frame, ev_rx_err, ev_rx_busy}), 32'b001);
        hr(12'h420, d);
        chk("R9 descriptor untouched", d, 32'h0044_4000);
        chk("R9 pointer held", rx_buf_addr, 32'h4000_0000);
    endtask

    task automatic t_rx_ctrl;
        logic [31:0] d;
        hw(12'h420, 32'h0000_C000);
        pulse_rx(16'd64, 9'h100);
        chk("R10 control bit not an error", 32'({ev_rx_frame, ev_rx_err}), 32'b10);
        hr(12'h420, d);
        chk("R7 control flag written", d, 32'h0040_4100);
        hw(12'h428, 32'h0000_A000);
        pulse_rx(16'd64, 9'h004);
        chk("R10 no event without irq bit", 32'({ev_rx_frame, ev_rx_err, ev_rx_busy}), 32'b000);
        hr(12'h428, d);
        chk("R7 wrap bit kept", d, 32'h0040_2004);
    endtask

    task automatic t_restart;
        hw(12'h020, 32'd2);
        @(negedge clk);
        @(negedge clk);
        chk("R2 rx ring moved to new base", rx_buf_addr, 32'h3000_0000);
        chk("R2 new base descriptor empty", 32'(rx_ready), 32'd1);
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_host();
        t_count();
        t_tx_basic();
        t_tx_wrap();
        t_rx();
        t_rx_busy();
        t_rx_ctrl();
        t_restart();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule